// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Clear-on-Compare

This block is an 8-bit timer/counter whose tick comes from a free-running clock prescaler. A 3-bit clock-select field picks the tick source: stopped, every system clock, or one of four divided taps (1/8, 1/64, 1/256, 1/1024). The prescaler never pauses, even while the counter is stopped. When the counter is enabled, its first divided tick can therefore arrive in fewer clocks than the division ratio. A software-controlled prescaler reset, with an optional hold bit, lets software start the timer at a known phase.

The block has two counting modes. In clear-on-compare mode the counter returns to zero on the tick after it equals the compare register. In normal mode it wraps from 255 to 0 and raises an overflow flag. A compare match sets a compare flag. Each flag drives an interrupt request through its own mask bit. All registers sit on a simple write strobe / combinational read bus. An acknowledge input clears the compare flag.

Top module: `tmr8_ctc_top`

## Requirements
- R1: After reset every register reads 0: CTRL (addr 0), COUNT (1), COMPARE (2), MASK (3), FLAGS (4), PSCTL (5). Both interrupt requests are low. A reset applied in mid-run returns MASK to 0, and no interrupt is requested until MASK is written again.
- R2: CTRL[2:0] selects the tick source: 0, 6 and 7 mean stopped, 1 means direct, and 2/3/4/5 mean divide by 8/64/256/1024. While stopped, the counter holds its value.
- R3: With select 1, the counter advances by exactly one on every clock edge, starting on the edge after the CTRL write.
- R4: With select 2, the counter advances exactly 8 clocks apart. Because the prescaler runs freely, the first advance after enabling comes within 8 clocks.
- R5: Writing PSCTL[0]=1 clears the prescaler. Without the hold bit, PSCTL[0] clears itself one clock later. The next divided advance then comes on the 9th edge after the write edge for divide by 8, and on the 65th for divide by 64.
- R6: Writing PSCTL with bits 7 and 0 both set holds the prescaler in reset, so no divided advance occurs. After PSCTL[7] is written back to 0, the first divide-by-8 advance comes on the 9th edge after that write edge.
- R7: In clear-on-compare mode (CTRL[3]=1), a tick with COUNT equal to COMPARE loads 0 instead of incrementing. The same tick sets FLAGS[0].
- R8: In normal mode (CTRL[3]=0), a tick at 255 wraps COUNT to 0 and sets FLAGS[1].
- R9: The compare interrupt request equals FLAGS[0] AND MASK[0]. The overflow request equals FLAGS[1] AND MASK[1].
- R10: Writing 1 to a FLAGS bit clears that flag, and writing 0 leaves it unchanged. A pulse on the acknowledge input clears FLAGS[0]. A flag being set in the same cycle wins over a clear.
- R11: A bus write to COUNT takes priority over a tick in the same clock.
- R12: Every tick changes COUNT by exactly one, even when bus writes to other registers happen in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_ack | input | 1 | Compare interrupt acknowledge pulse |
| irq_cmp | output | 1 | Compare-match interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
A register write lands on the clock edge that samples the strobe. A change to the clock select first affects COUNT one edge later, and a compare clear or flag set shows up on the edge of the matching tick. After a prescaler reset, the first divided advance is due on edge N+1, where N is the division ratio. Releasing the hold delays that advance by the same N+1 edges, counted from the release write. The bench drives and samples on the falling edge and counts edges explicitly from each write, so every check falls exactly on the cycle where a result is due or, for negative checks, on the last cycle before it.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int NTAP  = 4;
  localparam int TAP_LOG2 [NTAP] = '{3, 6, 8, 10};
  localparam int PSC_W = TAP_LOG2[NTAP-1];
  localparam int TW    = $clog2(NTAP);

  typedef enum logic [2:0] {
    CS_OFF   = 3'd0,
    CS_DIR   = 3'd1,
    CS_TAP0  = 3'd2
  } clksel_e;

  localparam logic [AW-1:0] A_CTRL  = 3'd0;
  localparam logic [AW-1:0] A_COUNT = 3'd1;
  localparam logic [AW-1:0] A_CMP   = 3'd2;
  localparam logic [AW-1:0] A_MASK  = 3'd3;
  localparam logic [AW-1:0] A_FLAGS = 3'd4;
  localparam logic [AW-1:0] A_PSCTL = 3'd5;

  localparam int B_CTC  = 3;
  localparam int B_PSR  = 0;
  localparam int B_HOLD = 7;
endpackage

// File: rtl/tmr8_presc.sv
module tmr8_presc
  import tmr8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ps_wr,
  input  logic            ps_psr_bit,
  input  logic            ps_hold_bit,
  output logic [NTAP-1:0] tap_hit,
  output logic            psr_q,
  output logic            hold_q
);
  logic [PSC_W-1:0] cnt_q, cnt_d;
  logic             psr_d, hold_d;

  always_comb begin
    cnt_d  = psr_q ? '0 : cnt_q + 1'b1;
    hold_d = ps_wr ? ps_hold_bit : hold_q;
    psr_d  = psr_q;
    if (ps_wr && ps_psr_bit) psr_d = 1'b1;
    else if (!hold_q)        psr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      psr_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      psr_q  <= psr_d;
      hold_q <= hold_d;
    end
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int LW = TAP_LOG2[g];
    assign tap_hit[g] = (&cnt_q[LW-1:0]) & ~psr_q;
  end

  // R4
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psr_q |=> cnt_q == $past(cnt_q) + 1'b1);
  // R6
  psr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_q && hold_q && !ps_wr) |=> (psr_q && cnt_q == '0));
  // R5
  psr_self_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_q && !hold_q && !(ps_wr && ps_psr_bit)) |=> !psr_q);
endmodule

// File: rtl/tmr8_clksel.sv
module tmr8_clksel
  import tmr8_pkg::*;
(
  input  logic [2:0]      sel,
  input  logic [NTAP-1:0] tap_hit,
  output logic            tick
);
  logic [2:0] off;

  always_comb begin
    off  = sel - CS_TAP0;
    tick = 1'b0;
    if (sel == CS_DIR)
      tick = 1'b1;
    else if (sel >= CS_TAP0 && {1'b0, sel} < 4'(int'(CS_TAP0) + NTAP))
      tick = tap_hit[off[TW-1:0]];
  end
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ctc,
  input  logic [DW-1:0] cmp_val,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  output logic [DW-1:0] cnt_q,
  output logic          match_ev,
  output logic          ovf_ev
);
  logic [DW-1:0] cnt_d;
  logic          hit;

  always_comb begin
    hit      = (cnt_q == cmp_val);
    match_ev = tick && !ld && hit;
    ovf_ev   = tick && !ld && !ctc && (&cnt_q);
    cnt_d    = cnt_q;
    if (ld)
      cnt_d = ld_val;
    else if (tick)
      cnt_d = (ctc && hit) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R11
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(ld_val));
  // R12
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && !(ctc && cnt_q == cmp_val)) |=> cnt_q == $past(cnt_q) + 8'd1);
  // R2
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(cnt_q));
  // R7
  ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && ctc && cnt_q == cmp_val) |=> cnt_q == '0);
endmodule

// File: rtl/tmr8_irq.sv
module tmr8_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_cmp,
  input  logic       set_ovf,
  input  logic       clr_cmp,
  input  logic       clr_ovf,
  input  logic       ack,
  input  logic [1:0] mask,
  output logic       cmp_q,
  output logic       ovf_q,
  output logic       irq_cmp,
  output logic       irq_ovf
);
  logic cmp_d, ovf_d;

  always_comb begin
    cmp_d = cmp_q;
    if (set_cmp)              cmp_d = 1'b1;
    else if (clr_cmp || ack)  cmp_d = 1'b0;
    ovf_d = ovf_q;
    if (set_ovf)              ovf_d = 1'b1;
    else if (clr_ovf)         ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      ovf_q <= ovf_d;
    end
  end

  assign irq_cmp = cmp_q & mask[0];
  assign irq_ovf = ovf_q & mask[1];

  // R10
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_cmp) |=> !cmp_q);
  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf |=> ovf_q);
  // R7
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_cmp |=> cmp_q);
endmodule

// File: rtl/tmr8_ctc_top.sv
module tmr8_ctc_top
  import tmr8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          irq_ack,
  output logic          irq_cmp,
  output logic          irq_ovf
);
  logic [1:0]      rs_q;
  logic            rst_ni;
  logic [2:0]      sel_q, sel_d;
  logic            ctc_q, ctc_d;
  logic [DW-1:0]   cmp_q, cmp_d;
  logic [1:0]      mask_q, mask_d;
  logic [NTAP-1:0] tap_hit;
  logic            psr_q, hold_q, tick;
  logic [DW-1:0]   cnt;
  logic            match_ev, ovf_ev, f_cmp, f_ovf;
  logic            wr_ctrl, wr_count, wr_cmp, wr_mask, wr_flags, wr_psctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  always_comb begin
    wr_ctrl  = bus_wr && bus_addr == A_CTRL;
    wr_count = bus_wr && bus_addr == A_COUNT;
    wr_cmp   = bus_wr && bus_addr == A_CMP;
    wr_mask  = bus_wr && bus_addr == A_MASK;
    wr_flags = bus_wr && bus_addr == A_FLAGS;
    wr_psctl = bus_wr && bus_addr == A_PSCTL;
    sel_d    = wr_ctrl ? bus_wdata[2:0]     : sel_q;
    ctc_d    = wr_ctrl ? bus_wdata[B_CTC]   : ctc_q;
    cmp_d    = wr_cmp  ? bus_wdata          : cmp_q;
    mask_d   = wr_mask ? bus_wdata[1:0]     : mask_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= CS_OFF;
      ctc_q  <= 1'b0;
      cmp_q  <= '0;
      mask_q <= '0;
    end else begin
      sel_q  <= sel_d;
      ctc_q  <= ctc_d;
      cmp_q  <= cmp_d;
      mask_q <= mask_d;
    end
  end

  tmr8_presc u_presc (
    .clk(clk), .rst_n(rst_ni), .ps_wr(wr_psctl),
    .ps_psr_bit(bus_wdata[B_PSR]), .ps_hold_bit(bus_wdata[B_HOLD]),
    .tap_hit(tap_hit), .psr_q(psr_q), .hold_q(hold_q)
  );

  tmr8_clksel u_sel (.sel(sel_q), .tap_hit(tap_hit), .tick(tick));

  tmr8_counter u_cnt (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .ctc(ctc_q), .cmp_val(cmp_q),
    .ld(wr_count), .ld_val(bus_wdata), .cnt_q(cnt),
    .match_ev(match_ev), .ovf_ev(ovf_ev)
  );

  tmr8_irq u_irq (
    .clk(clk), .rst_n(rst_ni), .set_cmp(match_ev), .set_ovf(ovf_ev),
    .clr_cmp(wr_flags && bus_wdata[0]), .clr_ovf(wr_flags && bus_wdata[1]),
    .ack(irq_ack), .mask(mask_q), .cmp_q(f_cmp), .ovf_q(f_ovf),
    .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {4'b0, ctc_q, sel_q};
      A_COUNT: bus_rdata = cnt;
      A_CMP:   bus_rdata = cmp_q;
      A_MASK:  bus_rdata = {6'b0, mask_q};
      A_FLAGS: bus_rdata = {6'b0, f_ovf, f_cmp};
      A_PSCTL: bus_rdata = {hold_q, 6'b0, psr_q};
      default: bus_rdata = '0;
    endcase
  end

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mask_q[0] |-> !irq_cmp) and (!mask_q[1] |-> !irq_ovf));
  // R1
  mask_rst_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_ni) |-> mask_q == 2'b00);
endmodule

// File: tb/tmr8_ctc_top_test.sv
`timescale 1ns/100ps
module tmr8_ctc_top_test;
  logic       clk = 1'b0;
  logic       rst_n, bus_wr, irq_ack;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq_cmp, irq_ovf;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr8_ctc_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
    .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    bus_addr = a; #0.5; v = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 8'd0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 register reset value", v, 0);
    end
    chk("R1 irq_cmp after reset", irq_cmp, 0);
    chk("R1 irq_ovf after reset", irq_ovf, 0);
  endtask

  task automatic t_stopped();
    logic [7:0] v;
    wr(3'd1, 8'd42);
    wr(3'd0, 8'd6);
    repeat (20) @(negedge clk);
    rd(3'd1, v);
    chk("R2 select 6 holds count", v, 42);
    wr(3'd0, 8'd0);
    repeat (20) @(negedge clk);
    rd(3'd1, v);
    chk("R2 select 0 holds count", v, 42);
  endtask

  task automatic t_direct();
    logic [7:0] v;
    wr(3'd1, 8'd0);
    wr(3'd0, 8'd1);
    rd(3'd1, v);
    chk("R3 no advance on ctrl write edge", v, 0);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      rd(3'd1, v);
      chk("R3 direct advance per clock", v, k);
    end
    wr(3'd0, 8'd0);
  endtask

  task automatic t_div8();
    logic [7:0] v, prev;
    int idx [4];
    int n = 0;
    wr(3'd1, 8'd0);
    wr(3'd0, 8'd2);
    rd(3'd1, prev);
    for (int k = 1; k <= 60 && n < 4; k++) begin
      @(negedge clk);
      rd(3'd1, v);
      if (v != prev) begin idx[n] = k; n++; prev = v; end
    end
    chk("R4 four divided ticks seen", n, 4);
    chk("R4 first tick within 8 clocks", (idx[0] >= 1 && idx[0] <= 8), 1);
    for (int i = 1; i < 4; i++)
      chk("R4 tick spacing 8", idx[i] - idx[i-1], 8);
  endtask

  task automatic t_psr(logic [2:0] sel, int ratio, string tag);
    logic [7:0] v, c0;
    wr(3'd0, {5'd0, sel});
    wr(3'd5, 8'h01);
    rd(3'd1, c0);
    repeat (ratio) @(negedge clk);
    rd(3'd1, v);
    chk({tag, " no advance before edge N+1"}, v, c0);
    rd(3'd5, v);
    chk({tag, " reset bit self-cleared"}, v, 0);
    @(negedge clk);
    rd(3'd1, v);
    chk({tag, " advance on edge N+1"}, v, c0 + 8'd1);
  endtask

  task automatic t_hold();
    logic [7:0] v, c0;
    wr(3'd0, 8'd2);
    wr(3'd5, 8'h81);
    rd(3'd1, c0);
    repeat (40) @(negedge clk);
    rd(3'd1, v);
    chk("R6 held prescaler gives no tick", v, c0);
    rd(3'd5, v);
    chk("R6 PSCTL reads hold and reset", v, 8'h81);
    wr(3'd5, 8'h00);
    repeat (8) @(negedge clk);
    rd(3'd1, v);
    chk("R6 no tick before 9th edge after release", v, c0);
    @(negedge clk);
    rd(3'd1, v);
    chk("R6 first tick on 9th edge after release", v, c0 + 8'd1);
    wr(3'd0, 8'd0);
  endtask

  task automatic t_ctc();
    logic [7:0] v;
    wr(3'd0, 8'h08);
    wr(3'd2, 8'd5);
    wr(3'd1, 8'd0);
    wr(3'd4, 8'h03);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h09);
    repeat (5) @(negedge clk);
    rd(3'd1, v);  chk("R7 count reaches compare", v, 5);
    rd(3'd4, v);  chk("R7 flag clear before match tick", v[0], 0);
    @(negedge clk);
    rd(3'd1, v);  chk("R7 cleared to zero after match", v, 0);
    rd(3'd4, v);  chk("R7 compare flag set", v[0], 1);
    chk("R9 masked compare request low", irq_cmp, 0);
    @(negedge clk);
    rd(3'd1, v);  chk("R7 counts on from zero", v, 1);
    wr(3'd0, 8'h08);
    wr(3'd3, 8'h01);
    chk("R9 compare request with mask", irq_cmp, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    rd(3'd4, v);  chk("R10 acknowledge clears compare flag", v[0], 0);
    chk("R10 request drops after acknowledge", irq_cmp, 0);
  endtask

  task automatic t_ovf();
    logic [7:0] v;
    wr(3'd0, 8'h00);
    wr(3'd2, 8'd7);
    wr(3'd1, 8'd253);
    wr(3'd4, 8'h03);
    wr(3'd3, 8'h02);
    wr(3'd0, 8'h01);
    repeat (2) @(negedge clk);
    rd(3'd1, v);  chk("R8 count at 255", v, 255);
    chk("R9 no overflow request yet", irq_ovf, 0);
    @(negedge clk);
    rd(3'd1, v);  chk("R8 wrap to zero", v, 0);
    rd(3'd4, v);  chk("R8 overflow flag set", v[1], 1);
    chk("R9 overflow request with mask", irq_ovf, 1);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h00);
    rd(3'd4, v);  chk("R10 writing 0 keeps flag", v[1], 1);
    wr(3'd4, 8'h02);
    rd(3'd4, v);  chk("R10 writing 1 clears flag", v[1], 0);
    chk("R10 overflow request drops", irq_ovf, 0);
  endtask

  task automatic t_load_step();
    logic [7:0] v, prev;
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h01);
    wr(3'd1, 8'd100);
    rd(3'd1, v);  chk("R11 write beats tick", v, 100);
    @(negedge clk);
    rd(3'd1, v);  chk("R11 counting resumes after load", v, 101);
    for (int k = 0; k < 8; k++) begin
      rd(3'd1, prev);
      bus_addr = (k % 2) ? 3'd2 : 3'd3; bus_wdata = 8'(k); bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(3'd1, v);
      chk("R12 single step under bus writes", v, prev + 8'd1);
    end
    wr(3'd0, 8'h00);
  endtask

  task automatic t_midrun_reset();
    logic [7:0] v;
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h01);
    do_reset();
    rd(3'd3, v);  chk("R1 mask cleared by reset", v, 0);
    rd(3'd0, v);  chk("R1 ctrl cleared by reset", v, 0);
    chk("R1 no compare request after reset", irq_cmp, 0);
    chk("R1 no overflow request after reset", irq_ovf, 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_stopped();
    t_direct();
    t_div8();
    t_psr(3'd2, 8, "R5 div8");
    t_psr(3'd3, 64, "R5 div64");
    t_hold();
    t_ctc();
    t_ovf();
    t_load_step();
    t_midrun_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule